// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write Guard

This unit keeps the status byte of a serial EEPROM and decides, every cycle, whether a write to the memory array or a write to the status byte itself may go ahead. It holds a write-enable latch, two block-protect bits and a hardware-lock enable bit. It reports the ready/busy state given by the programming engine on its busy input. The command decoder that surrounds it drives single-cycle strobes to set or clear the latch and to load a new status byte, and shows the candidate array address. It then reads back the status byte and the two permit outputs.

Block protection works by quarters of the address space, selected by the top two address bits. A hardware lock exists only while the lock pin is held low and the lock-enable bit is set. While it is active, the status byte is frozen, so the lock-enable bit cannot be cleared until the pin goes high. Array writes outside the protected quarters stay allowed while the lock is active. The protect bits, which are nonvolatile in a real part, are modelled here as registers with a parameterised reset value.

Top module: `eeprom_sr_guard`

## Requirements
- R1: After reset, with default parameters, the status byte reads 0x00 and both permit outputs are 0.
- R2: A set strobe makes the write-enable flag (status bit 1) 1 on the next cycle and a clear strobe makes it 0. When both strobes arrive in the same cycle, the clear wins.
- R3: When not busy, the status byte is {lock-enable in bit 7, 0 in bits 6..4, protect code in bits 3..2, write-enable in bit 1, 0 in bit 0}.
- R4: While the busy input is 1, the status byte reads 0xFF and the array permit is 0.
- R5: A status-load strobe that is permitted copies data bit 7 into the lock-enable bit and data bits 3..2 into the protect code on the next cycle. The other data bits have no effect. The strobe is ignored while write-enable is 0.
- R6: The protect code selects the protected quarter range, where the quarter is the top two address bits. Code 00 protects none, 01 protects quarter 3, 10 protects quarters 2 and 3, and 11 protects all quarters.
- R7: The array permit is 1 exactly when write-enable is 1, busy is 0 and the address is not protected.
- R8: The hardware lock is active only when the lock pin is 0 and lock-enable is 1. While it is active, the status permit is 0 and load strobes leave the status byte unchanged. When the pin is 1, the status permit equals write-enable.
- R9: While the lock pin is 0 and lock-enable is 1, lock-enable stays 1, even after a load strobe with data bit 7 = 0.
- R10: The clear strobe clears write-enable whatever the lock pin and lock-enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wen_set_i | input | 1 | Strobe: set write-enable |
| wen_clr_i | input | 1 | Strobe: clear write-enable |
| sr_wr_i | input | 1 | Strobe: load status byte from sr_data_i |
| sr_data_i | input | 8 | New status byte value |
| busy_i | input | 1 | Internal programming cycle in progress |
| hw_lock_n_i | input | 1 | Hardware lock pin, active low |
| wr_addr_i | input | ADDR_W | Candidate array write address |
| status_o | output | 8 | Status byte |
| arr_wr_ok_o | output | 1 | Array write permitted |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
A wrong write-enable latch shows at once on status bit 1 and on both permit outputs, one cycle after the strobe that should have changed it. A protect code or lock-enable bit stored wrong shows on status bits 3..2 and 7 in the cycle after the load strobe. It also shows on the array permit for the first address whose quarter decodes differently. A broken lock shows as a status byte that changes while the pin is low, which is visible one cycle after the rejected load. Busy masking is purely combinational and shows in the same cycle as the busy input.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

  localparam int unsigned SR_W = 8;

  typedef struct packed {
    logic       lock_en;
    logic [2:0] rsvd;
    logic [1:0] prot;
    logic       wen;
    logic       busy;
  } sr_byte_t;

  localparam logic [SR_W-1:0] SR_BUSY_VAL = '1;

endpackage

// File: rtl/sr_rst_sync.sv
module sr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sr_wen_latch.sv
module sr_wen_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wen_o
);

  logic wen_q;
  logic wen_d;
  logic wen_ce;

  always_comb begin
    wen_ce = set_i | clr_i;
    wen_d  = set_i & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wen_q <= 1'b0;
    else if (wen_ce) wen_q <= wen_d;
  end

  assign wen_o = wen_q;

endmodule

// File: rtl/sr_prot_regs.sv
module sr_prot_regs
  import sr_guard_pkg::*;
#(
  parameter logic [1:0] RST_PROT    = 2'b00,
  parameter logic       RST_LOCK_EN = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  sr_byte_t   data_i,
  output logic [1:0] prot_o,
  output logic       lock_en_o
);

  logic [1:0] prot_q,    prot_d;
  logic       lock_en_q, lock_en_d;
  logic       data_unused;

  assign data_unused = ^{data_i.rsvd, data_i.wen, data_i.busy};

  always_comb begin
    prot_d    = data_i.prot;
    lock_en_d = data_i.lock_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q    <= RST_PROT;
      lock_en_q <= RST_LOCK_EN;
    end else if (load_i) begin
      prot_q    <= prot_d;
      lock_en_q <= lock_en_d;
    end
  end

  assign prot_o    = prot_q;
  assign lock_en_o = lock_en_q;

endmodule

// File: rtl/sr_quarter_decode.sv
module sr_quarter_decode #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [1:0]        prot_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  localparam int unsigned NQ = 4;

  logic [NQ-1:0] qmask;
  logic [1:0]    quarter;
  logic [ADDR_W-3:0] addr_unused;

  assign quarter     = addr_i[ADDR_W-1 -: 2];
  assign addr_unused = addr_i[ADDR_W-3:0];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign qmask[q] = (prot_i == 2'b11) |
                      ((prot_i == 2'b10) & (q >= NQ/2)) |
                      ((prot_i == 2'b01) & (q == NQ-1));
  end

  assign hit_o = qmask[quarter];

endmodule

// File: rtl/eeprom_sr_guard.sv
module eeprom_sr_guard
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W      = 14,
  parameter logic [1:0]  RST_PROT    = 2'b00,
  parameter logic        RST_LOCK_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen_set_i,
  input  logic              wen_clr_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              busy_i,
  input  logic              hw_lock_n_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [7:0]        status_o,
  output logic              arr_wr_ok_o,
  output logic              sr_wr_ok_o
);

  logic       rst_sync_n;
  logic       wen;
  logic [1:0] prot;
  logic       lock_en;
  logic       hw_lock;
  logic       sr_load;
  logic       addr_hit;
  sr_byte_t   sr_now;

  sr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sr_wen_latch u_wen (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (wen_set_i),
    .clr_i (wen_clr_i),
    .wen_o (wen)
  );

  always_comb begin
    hw_lock = lock_en & ~hw_lock_n_i;
    sr_load = sr_wr_i & wen & ~hw_lock;
  end

  sr_prot_regs #(
    .RST_PROT    (RST_PROT),
    .RST_LOCK_EN (RST_LOCK_EN)
  ) u_prot (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (sr_load),
    .data_i    (sr_byte_t'(sr_data_i)),
    .prot_o    (prot),
    .lock_en_o (lock_en)
  );

  sr_quarter_decode #(.ADDR_W(ADDR_W)) u_dec (
    .prot_i (prot),
    .addr_i (wr_addr_i),
    .hit_o  (addr_hit)
  );

  always_comb begin
    sr_now.lock_en = lock_en;
    sr_now.rsvd    = 3'b000;
    sr_now.prot    = prot;
    sr_now.wen     = wen;
    sr_now.busy    = 1'b0;
    status_o       = busy_i ? SR_BUSY_VAL : sr_now;
    arr_wr_ok_o    = wen & ~busy_i & ~addr_hit;
    sr_wr_ok_o     = wen & ~hw_lock;
  end

endmodule

// File: rtl/eeprom_sr_guard_chk.sv
module eeprom_sr_guard_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wen_set_i,
  input logic              wen_clr_i,
  input logic              busy_i,
  input logic              hw_lock_n_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        status_o,
  input logic              arr_wr_ok_o,
  input logic              sr_wr_ok_o
);

  // R4
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (status_o == 8'hFF && !arr_wr_ok_o));

  // R3
  idle_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (status_o[6:4] == 3'b000 && !status_o[0]));

  // R2
  wen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wen_clr_i |=> (busy_i || !status_o[1]));

  // R2
  wen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_set_i && !wen_clr_i && $past(rst_n)) |=> (busy_i || status_o[1]));

  // R8
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && status_o[7] && !hw_lock_n_i) |-> !sr_wr_ok_o);

  // R9
  lock_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && status_o[7] && !hw_lock_n_i) |=> (busy_i || status_o[7]));

  // R6
  full_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok_o |-> (status_o[3:2] != 2'b11));

  // R7
  top_quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_ok_o && wr_addr_i[ADDR_W-1 -: 2] == 2'b11) |-> (status_o[3:2] == 2'b00));

endmodule

bind eeprom_sr_guard eeprom_sr_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wen_set_i   (wen_set_i),
  .wen_clr_i   (wen_clr_i),
  .busy_i      (busy_i),
  .hw_lock_n_i (hw_lock_n_i),
  .wr_addr_i   (wr_addr_i),
  .status_o    (status_o),
  .arr_wr_ok_o (arr_wr_ok_o),
  .sr_wr_ok_o  (sr_wr_ok_o)
);

// File: tb/eeprom_sr_guard_tb.sv
module eeprom_sr_guard_tb;

  localparam int unsigned AW = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wen_set_i, wen_clr_i, sr_wr_i, busy_i, hw_lock_n_i;
  logic [7:0]    sr_data_i;
  logic [AW-1:0] wr_addr_i;
  logic [7:0]    status_o;
  logic          arr_wr_ok_o, sr_wr_ok_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  eeprom_sr_guard #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wen_set_i(wen_set_i), .wen_clr_i(wen_clr_i),
    .sr_wr_i(sr_wr_i), .sr_data_i(sr_data_i), .busy_i(busy_i),
    .hw_lock_n_i(hw_lock_n_i), .wr_addr_i(wr_addr_i), .status_o(status_o),
    .arr_wr_ok_o(arr_wr_ok_o), .sr_wr_ok_o(sr_wr_ok_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [1:0] p, input logic [AW-1:0] a);
    logic [1:0] q = a[AW-1 -: 2];
    case (p)
      2'b00:   return 1'b0;
      2'b01:   return q == 2'b11;
      2'b10:   return q[1];
      default: return 1'b1;
    endcase
  endfunction

  task automatic strobe(input logic s, input logic c, input logic w, input logic [7:0] d);
    @(negedge clk);
    wen_set_i = s; wen_clr_i = c; sr_wr_i = w; sr_data_i = d;
    @(negedge clk);
    wen_set_i = 0; wen_clr_i = 0; sr_wr_i = 0; sr_data_i = 8'h00;
  endtask

  task automatic t_reset;
    rst_n = 0; wen_set_i = 0; wen_clr_i = 0; sr_wr_i = 0; sr_data_i = 0;
    busy_i = 0; hw_lock_n_i = 1; wr_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 status", status_o, 8'h00);
    chk("R1 arr_ok", arr_wr_ok_o, 0);
    chk("R1 sr_ok", sr_wr_ok_o, 0);
  endtask

  task automatic t_wen;
    strobe(1, 0, 0, 0);
    chk("R2 set", status_o, 8'h02);
    chk("R8 sr_ok follows wen", sr_wr_ok_o, 1);
    strobe(0, 1, 0, 0);
    chk("R2 clr", status_o, 8'h00);
    strobe(1, 0, 0, 0);
    strobe(1, 1, 0, 0);
    chk("R2 clr wins", status_o, 8'h00);
  endtask

  task automatic t_layout;
    strobe(0, 0, 1, 8'hFF);
    chk("R5 ignored when wen=0", status_o, 8'h00);
    strobe(1, 0, 0, 0);
    strobe(0, 0, 1, 8'hFF);
    chk("R3 R5 layout", status_o, 8'h8E);
    strobe(0, 0, 1, 8'h70);
    chk("R5 clear fields", status_o, 8'h02);
  endtask

  task automatic t_busy;
    wr_addr_i = '0;
    @(negedge clk); busy_i = 1;
    #1;
    chk("R4 status", status_o, 8'hFF);
    chk("R4 arr_ok", arr_wr_ok_o, 0);
    @(negedge clk); busy_i = 0;
    #1;
    chk("R4 back", status_o, 8'h02);
    chk("R7 arr_ok idle", arr_wr_ok_o, 1);
  endtask

  task automatic t_quarters;
    logic [AW-1:0] addrs [4];
    addrs[0] = 14'h0FFF; addrs[1] = 14'h1000; addrs[2] = 14'h2FFF; addrs[3] = 14'h3000;
    for (int p = 0; p < 4; p++) begin
      strobe(0, 0, 1, {4'b0000, p[1:0], 2'b00});
      chk("R5 prot loaded", status_o[3:2], p[1:0]);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); wr_addr_i = addrs[i];
        #1;
        chk("R6 R7 quarter permit", arr_wr_ok_o, !exp_hit(p[1:0], addrs[i]));
      end
    end
    strobe(0, 0, 1, 8'h00);
  endtask

  task automatic t_lock;
    strobe(0, 0, 1, 8'h84);
    chk("R5 lock_en load", status_o, 8'h86);
    @(negedge clk); hw_lock_n_i = 0;
    #1;
    chk("R8 sr_ok locked", sr_wr_ok_o, 0);
    strobe(0, 0, 1, 8'h00);
    chk("R9 lock_en kept", status_o, 8'h86);
    wr_addr_i = 14'h0000; #1;
    chk("R8 unprot allowed", arr_wr_ok_o, 1);
    wr_addr_i = 14'h3000; #1;
    chk("R8 prot denied", arr_wr_ok_o, 0);
    strobe(0, 1, 0, 0);
    chk("R10 clr while locked", status_o, 8'h84);
    strobe(1, 0, 0, 0);
    @(negedge clk); hw_lock_n_i = 1;
    #1;
    chk("R8 released", sr_wr_ok_o, 1);
    strobe(0, 0, 1, 8'h00);
    chk("R8 write after release", status_o, 8'h02);
    @(negedge clk); hw_lock_n_i = 0;
    #1;
    chk("R8 pin low lock_en=0", sr_wr_ok_o, 1);
    hw_lock_n_i = 1;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_wen();
    t_layout();
    t_busy();
    t_quarters();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule